// File: doc/BRIEF.md
# Two-Level Vectoring Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core must break off and branch to an interrupt routine, and to which address. It watches five request sources: two active-low external pins, two timer overflow pulses and one serial flag. It keeps latched flags for edge-mode pins and for timer overflows, masks them with a global enable and per-source enables, and resolves which pending request wins. A per-source priority bit chooses between two levels. A fixed polling order breaks ties inside a level.

Requests are sampled on each machine-cycle strobe and acted on at the next strobe. When a winner is allowed, the controller pulses a call request with the routine's vector address. It also marks the winner's level as in service and clears the winner's flag where the source is self-clearing. A return-from-interrupt pulse releases the highest level in service. Calls are held back while an equal or higher level is in service. They are also held back in any machine cycle that carries a return or a write to the enable or priority register.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset no call is produced, `lvl_busy` reads 0 and every enable is clear, so a pending request alone does not cause a call.
- R2: Vector addresses are fixed: external 0 → 0x0003, timer 0 → 0x000B, external 1 → 0x0013, timer 1 → 0x001B, serial → 0x0023 (base 3, stride 8 in polling order).
- R3: A pending request whose priority bit is 1 (high) wins over any pending low-level request, whatever their polling positions. Priority register (`reg_sel`=1) bits 0..4 belong to ext0, tmr0, ext1, tmr1 and serial.
- R4: Within one level the winner follows the polling order ext0, tmr0, ext1, tmr1, serial, from highest to lowest.
- R5: Enable register (`reg_sel`=0): bit 7 is the global enable and bits 0..4 are the per-source enables in polling order. A source calls only when both its bit and bit 7 are set. A flag latched while disabled is kept and is taken once it is enabled.
- R6: With its mode bit at 0, an external pin requests while it is low and nothing is latched. A low pulse that ends before a sampling strobe causes no call.
- R7: Mode register (`reg_sel`=2): bit 0 is ext0 and bit 1 is ext1. With the bit at 1, a falling edge latches a flag that requests even after the pin returns high. The flag is cleared when its call is issued.
- R8: A timer overflow pulse latches a flag that is cleared when its call is issued. The serial request is a level that the controller never clears, so it calls again after the return while it stays high.
- R9: A request sampled at one strobe is called at the following strobe, never at the sampling strobe itself.
- R10: No call is issued while a routine of equal or higher level is in service. A high request preempts a low routine. `lvl_busy` bit 1 is the high level and bit 0 is the low level, and a return pulse clears the highest set bit.
- R11: A return pulse or a write to the enable or priority register in a machine cycle blocks the call at that cycle's closing strobe. The request is taken at a later strobe if it is still pending. Mode-register writes do not block.
- R12: `call_req` is a single-clock pulse on the clock after a strobe, and `call_vec` holds the vector issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_stb | input | 1 | Machine-cycle strobe, one clock wide |
| reti_p | input | 1 | Return-from-interrupt pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 priority, 2 mode |
| reg_wdata | input | 8 | Register write data |
| ext_pin_n | input | 2 | Active-low external request pins |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_req | input | 1 | Serial request level |
| call_req | output | 1 | Call pulse to the core |
| call_vec | output | 16 | Vector address of the issued call |
| lvl_busy | output | 2 | In-service levels, bit 1 high, bit 0 low |

## Verification
The bench builds the controller with its default parameters: a two-stage pin synchronizer, a 16-bit vector bus, base 3 and stride 8. At these values every vector is a distinct small constant, and the synchronizer latency is short enough that a pin pulse fits between two strobes. That lets the bench place pin edges, timer pulses, register writes and return pulses at chosen points inside a machine cycle. With that control it can check sample-then-call timing, preemption across the two levels, and deferral of calls one strobe at a time.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC   = 5;
  localparam int NEXT   = 2;
  localparam int IDX_W  = $clog2(NSRC);

  // source order is the polling order (index 0 wins ties)
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;

  // sources whose flag is dropped when their call is issued
  localparam logic [NSRC-1:0] CLR_ON_CALL = 5'b01111;

  typedef enum logic [1:0] {
    SEL_ENA  = 2'd0,
    SEL_PRI  = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    LVL_LO = 2'b01,
    LVL_HI = 2'b10
  } lvl_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  // pins idle high, so reset to 1 avoids a false falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags
  import irq_vec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_pin_n,
  input  logic [NEXT-1:0] ext_mode,
  input  logic [NEXT-1:0] tmr_ovf,
  input  logic            ser_req,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] req
);
  // external i sits at index 2*i, its timer at 2*i+1
  for (genvar i = 0; i < NEXT; i++) begin : g_pair
    logic pin_s;
    logic prev_q, prev_d;
    logic eflag_q, eflag_d;
    logic tflag_q, tflag_d;
    logic fall;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ext_pin_n[i]),
      .dout (pin_s)
    );

    always_comb begin
      fall    = prev_q & ~pin_s;
      prev_d  = pin_s;
      eflag_d = (fall & ext_mode[i]) | (eflag_q & ~clr_mask[2*i]);
      tflag_d = tmr_ovf[i] | (tflag_q & ~clr_mask[2*i+1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b1;
        eflag_q <= 1'b0;
        tflag_q <= 1'b0;
      end else begin
        prev_q  <= prev_d;
        eflag_q <= eflag_d;
        tflag_q <= tflag_d;
      end
    end

    assign req[2*i]   = ext_mode[i] ? eflag_q : ~pin_s;
    assign req[2*i+1] = tflag_q;
  end

  assign req[SRC_SER] = ser_req;
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_vec_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  prio,
  output logic             any,
  output logic             win_hi,
  output logic [IDX_W-1:0] win_idx
);
  logic [NSRC-1:0] hi_set, lo_set, pick;

  always_comb begin
    hi_set  = pend & prio;
    lo_set  = pend & ~prio;
    win_hi  = |hi_set;
    pick    = win_hi ? hi_set : lo_set;
    any     = |pend;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pick[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_vec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  logic       set_hi,
  input  logic       reti,
  input  logic       win_hi,
  output logic       grant_ok,
  output logic [1:0] busy
);
  logic [1:0] busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (reti) begin
      if (busy_q[1]) busy_d[1] = 1'b0;
      else           busy_d[0] = 1'b0;
    end
    if (set_en) busy_d = busy_d | (set_hi ? LVL_HI : LVL_LO);
    // high may only enter when high is idle; low needs both idle
    grant_ok = win_hi ? ~busy_q[1] : (busy_q == 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 2'b00;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int REG_W       = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8,
  parameter int GEN_BIT     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_stb,
  input  logic              reti_p,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [NEXT-1:0]   ext_pin_n,
  input  logic [NEXT-1:0]   tmr_ovf,
  input  logic              ser_req,
  output logic              call_req,
  output logic [ADDR_W-1:0] call_vec,
  output logic [1:0]        lvl_busy
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // configuration registers
  logic [NSRC-1:0] ena_q, ena_d, pri_q, pri_d;
  logic [NEXT-1:0] mode_q, mode_d;
  logic            gen_q, gen_d;
  logic            wr_ena, wr_pri, wr_mode;

  always_comb begin
    wr_ena  = reg_we & (reg_sel == SEL_ENA);
    wr_pri  = reg_we & (reg_sel == SEL_PRI);
    wr_mode = reg_we & (reg_sel == SEL_MODE);
    ena_d   = wr_ena  ? reg_wdata[NSRC-1:0] : ena_q;
    gen_d   = wr_ena  ? reg_wdata[GEN_BIT]  : gen_q;
    pri_d   = wr_pri  ? reg_wdata[NSRC-1:0] : pri_q;
    mode_d  = wr_mode ? reg_wdata[NEXT-1:0] : mode_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ena_q  <= '0;
      gen_q  <= 1'b0;
      pri_q  <= '0;
      mode_q <= '0;
    end else begin
      ena_q  <= ena_d;
      gen_q  <= gen_d;
      pri_q  <= pri_d;
      mode_q <= mode_d;
    end
  end

  // request flags
  logic [NSRC-1:0] req, clr_mask;

  irq_src_flags #(.SYNC_STAGES(SYNC_STAGES)) u_flags (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ext_pin_n(ext_pin_n),
    .ext_mode (mode_q),
    .tmr_ovf  (tmr_ovf),
    .ser_req  (ser_req),
    .clr_mask (clr_mask),
    .req      (req)
  );

  // blocking window: any return or enable/priority write within the
  // machine cycle that closes at the next strobe
  logic blk_q, blk_d, blk_now;

  always_comb begin
    blk_now = blk_q | reti_p | wr_ena | wr_pri;
    blk_d   = mc_stb ? 1'b0 : blk_now;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) blk_q <= 1'b0;
    else          blk_q <= blk_d;
  end

  // sampled requests, polled at the following strobe
  logic [NSRC-1:0]  smp_q, smp_d;
  logic             any, win_hi, grant_ok, fire;
  logic [IDX_W-1:0] win_idx;

  irq_resolve u_res (
    .pend   (smp_q),
    .prio   (pri_q),
    .any    (any),
    .win_hi (win_hi),
    .win_idx(win_idx)
  );

  irq_level_track u_lvl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_en  (fire),
    .set_hi  (win_hi),
    .reti    (reti_p),
    .win_hi  (win_hi),
    .grant_ok(grant_ok),
    .busy    (lvl_busy)
  );

  always_comb begin
    fire     = mc_stb & any & grant_ok & ~blk_now;
    clr_mask = '0;
    if (fire) clr_mask[win_idx] = CLR_ON_CALL[win_idx];
    smp_d    = mc_stb ? (req & ena_q & {NSRC{gen_q}} & ~clr_mask) : smp_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) smp_q <= '0;
    else          smp_q <= smp_d;
  end

  // call output
  logic              call_q;
  logic [ADDR_W-1:0] vec_q, vec_d;

  always_comb begin
    vec_d = fire ? (ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STEP)) : vec_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      call_q <= fire;
      vec_q  <= vec_d;
    end
  end

  assign call_req = call_q;
  assign call_vec = vec_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mc_stb,
  input logic              reti_p,
  input logic              call_req,
  input logic [ADDR_W-1:0] call_vec,
  input logic [1:0]        lvl_busy
);
  // a call only follows a strobe by one clock
  p_after_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(mc_stb));

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  // vector lies on the table grid
  p_vec_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec >= ADDR_W'(VEC_BASE)) &&
                 (call_vec <= ADDR_W'(VEC_BASE + 4 * VEC_STEP)) &&
                 (((call_vec - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STEP)) == '0));

  // a call marks a level busy
  p_call_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (lvl_busy != 2'b00));

  // high in service blocks everything
  p_hi_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(lvl_busy[1]));

  // no call on the strobe that carried a return
  p_reti_defers_r11: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(reti_p));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .VEC_BASE(VEC_BASE),
  .VEC_STEP(VEC_STEP)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mc_stb  (mc_stb),
  .reti_p  (reti_p),
  .call_req(call_req),
  .call_vec(call_vec),
  .lvl_busy(lvl_busy)
);

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mc_stb, reti_p, reg_we, ser_req;
  logic [1:0]  reg_sel, ext_pin_n, tmr_ovf, lvl_busy;
  logic [7:0]  reg_wdata;
  logic        call_req;
  logic [15:0] call_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .reti_p(reti_p),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf), .ser_req(ser_req),
    .call_req(call_req), .call_vec(call_vec), .lvl_busy(lvl_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mc_stb = 0; reti_p = 0; reg_we = 0; reg_sel = 0;
    reg_wdata = 0; ext_pin_n = 2'b11; tmr_ovf = 0; ser_req = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reti();
    reti_p = 1;
    @(negedge clk);
    reti_p = 0;
  endtask

  task automatic tpulse(input int i);
    tmr_ovf[i] = 1'b1;
    @(negedge clk);
    tmr_ovf = 2'b00;
  endtask

  task automatic set_pin(input int i, input logic v);
    ext_pin_n[i] = v;
    idle(4);
  endtask

  // one machine cycle: strobe clock plus three idle clocks
  task automatic mc(output bit c, output logic [15:0] v);
    mc_stb = 1;
    @(negedge clk);
    mc_stb = 0;
    c = call_req;
    v = call_vec;
    @(negedge clk);
    if (c) chk(call_req == 1'b0, "R12 pulse width", call_req, 0);
    idle(2);
  endtask

  task automatic expect_call(input logic [15:0] exp, input string tag, input int maxmc);
    bit c = 0;
    logic [15:0] v = 0;
    for (int k = 0; k < maxmc && !c; k++) mc(c, v);
    chk(c && v == exp, tag, c ? int'(v) : -1, exp);
  endtask

  task automatic expect_none(input int n, input string tag);
    bit c, any = 0;
    logic [15:0] v;
    for (int k = 0; k < n; k++) begin
      mc(c, v);
      if (c) any = 1;
    end
    chk(!any, tag, any, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(call_req == 0 && lvl_busy == 0, "R1 reset outputs", {call_req, lvl_busy}, 0);
    tpulse(0);
    ext_pin_n = 2'b00; ser_req = 1;
    idle(4);
    expect_none(3, "R1 enables clear after reset");
    ext_pin_n = 2'b11; ser_req = 0;
  endtask

  task automatic t_vectors();
    for (int i = 0; i < 5; i++) begin
      do_reset();
      wr(2'd0, 8'h80 | (8'h01 << i));
      case (i)
        0: ext_pin_n[0] = 0;
        1: tpulse(0);
        2: ext_pin_n[1] = 0;
        3: tpulse(1);
        default: ser_req = 1;
      endcase
      idle(4);
      expect_call(16'(3 + 8 * i), "R2 vector", 3);
      ext_pin_n = 2'b11; ser_req = 0;
    end
  endtask

  task automatic t_poll();
    do_reset();
    wr(2'd0, 8'h9F);
    wr(2'd2, 8'h03);
    ext_pin_n = 2'b00; idle(4);
    ext_pin_n = 2'b11; idle(4);
    tpulse(0); tpulse(1);
    ser_req = 1;
    expect_call(16'h0003, "R4 order ext0", 4);  reti();
    expect_call(16'h000B, "R4 order tmr0", 4);  reti();
    expect_call(16'h0013, "R4 order ext1", 4);  reti();
    expect_call(16'h001B, "R4 order tmr1", 4);  reti();
    expect_call(16'h0023, "R4 order serial", 4);
    ser_req = 0;
    reti();
  endtask

  task automatic t_prio();
    do_reset();
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h9F);
    tpulse(0);
    ser_req = 1;
    expect_call(16'h0023, "R3 high beats low", 3);
    chk(lvl_busy == 2'b10, "R10 high busy", lvl_busy, 2);
    expect_none(3, "R10 high in service blocks");
    reti();
    expect_call(16'h0023, "R8 serial not cleared", 4);
    ser_req = 0;
    reti();
    expect_call(16'h000B, "R3 low after high", 4);
    reti();
  endtask

  task automatic t_preempt();
    do_reset();
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h9F);
    tpulse(1);
    expect_call(16'h001B, "R10 low call", 3);
    chk(lvl_busy == 2'b01, "R10 low busy", lvl_busy, 1);
    tpulse(0);
    expect_none(3, "R10 equal level blocked");
    set_pin(0, 0); set_pin(0, 1);
    expect_call(16'h0003, "R10 high preempts", 3);
    chk(lvl_busy == 2'b11, "R10 both busy", lvl_busy, 3);
    reti();
    chk(lvl_busy == 2'b01, "R10 return clears high first", lvl_busy, 1);
    expect_none(2, "R10 low still blocks low");
    reti();
    chk(lvl_busy == 2'b00, "R10 second return", lvl_busy, 0);
    expect_call(16'h000B, "R8 timer flag held", 4);
    reti();
    expect_none(3, "R8 timer flag cleared");
  endtask

  task automatic t_pins();
    do_reset();
    wr(2'd0, 8'h84);
    set_pin(1, 0); set_pin(1, 1);
    expect_none(3, "R6 short low not latched");
    set_pin(1, 0);
    expect_call(16'h0013, "R6 level low requests", 3);
    ext_pin_n[1] = 1; idle(4);
    reti();
    wr(2'd2, 8'h02);
    set_pin(1, 0); set_pin(1, 1);
    expect_call(16'h0013, "R7 edge latched", 3);
    reti();
    expect_none(3, "R7 edge flag cleared");
  endtask

  task automatic t_gate();
    bit c;
    logic [15:0] v;
    do_reset();
    tpulse(0);
    wr(2'd0, 8'h02);
    expect_none(3, "R5 global off");
    wr(2'd0, 8'h80);
    expect_none(3, "R5 source off");
    wr(2'd0, 8'h82);
    expect_call(16'h000B, "R5 latched flag taken", 3);
    reti();
    // sampling timing
    tpulse(0);
    mc(c, v);
    chk(!c, "R9 no call at sampling strobe", c, 0);
    mc(c, v);
    chk(c && v == 16'h000B, "R9 call at next strobe", c, 1);
    reti();
  endtask

  task automatic t_block();
    bit c;
    logic [15:0] v;
    do_reset();
    wr(2'd0, 8'h9F);
    tpulse(0);
    mc(c, v);
    wr(2'd0, 8'h9F);
    mc(c, v);
    chk(!c, "R11 enable write defers", c, 0);
    mc(c, v);
    chk(c && v == 16'h000B, "R11 taken after defer", c, 1);
    reti();
    idle(4);
    tpulse(1);
    mc(c, v);
    wr(2'd1, 8'h00);
    mc(c, v);
    chk(!c, "R11 priority write defers", c, 0);
    mc(c, v);
    chk(c && v == 16'h001B, "R11 taken after priority write", c, 1);
    reti();
    idle(4);
    tpulse(0);
    mc(c, v);
    wr(2'd2, 8'h00);
    mc(c, v);
    chk(c && v == 16'h000B, "R11 mode write does not defer", c, 1);
    reti();
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_poll();
    t_prio();
    t_preempt();
    t_pins();
    t_gate();
    t_block();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule